// File: doc/BRIEF.md
# Host Controller Interrupt and Command Register Block

This block holds the event and command registers of an embedded USB host controller. Internal controller logic reports events as one-cycle pulses. Each pulse latches a sticky bit in an interrupt status register, and software clears that bit later by writing 1 to it. A separate enable register has one enable per status bit and a master enable. Together they gate a single combined interrupt line to the host processor.

A command status register carries two things. The first is a 2-bit counter of scheduling overruns, which keeps counting while the overrun flag is still pending. The second is a controller-reset bit that clears itself. Setting that bit starts a software reset of the controller through a request/done handshake with an external reset sequencer. Starting the reset flushes the interrupt registers. A cycle counter checks the handshake against a time bound set as a parameter.

Software reaches the block through a register bus. A valid cycle carries an 8-bit command code: bit 7 set means write, bit 7 clear means read, and bits 6:0 select the register. The codes are 0x02 for command status, 0x03 for interrupt status and 0x04 for interrupt enable. Read data is combinational in the same cycle as the command. A write takes effect at the clock edge that ends the command cycle.

The reset handshake is a three-state machine:
- `RST_IDLE` is the start state. It moves to `RST_BUSY` (start) on a write of 1 to bit 0 of command status.
- `RST_BUSY` returns to `RST_IDLE` (done) when the done input is high. If the done input is still low after `RST_LIMIT` cycles, it moves to `RST_LATE` (timeout).
- `RST_LATE` returns to `RST_IDLE` (late done) when the done input arrives.

Top module: `hc_status_regs`

## Requirements
- R1: Status bit 0 is set by `sched_ovr_i`, and status bit k (k ≥ 1) is set by `evt_i[k-1]`. Each bit reads as 1 through code 0x03 from the cycle after the pulse. Writing a 1 to a clear status bit leaves it clear.
- R2: A write with code 0x83 clears exactly the status bits whose data bit is 1. Bits written with 0 keep their value.
- R3: When an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R4: `irq_o` is 1 exactly when some status bit and its enable bit are both 1 and the master enable is 1. Code 0x84 writes the enables to bits [ST_W-1:0] and the master enable to bit 31. Code 0x04 reads them back at the same positions.
- R5: Command status bits 17:16 (code 0x02) count overrun pulses. The count starts at 00, adds one per pulse, wraps from 11 to 00, and keeps counting while status bit 0 is already set.
- R6: Writing 1 to bit 0 with code 0x82 while idle sets command status bit 0 and `rst_req_o` from the next cycle. Both return to 0 in the cycle after `rst_done_i` is seen high.
- R7: Starting a reset clears the interrupt status, enable and master enable, and the overrun count. An event pulse in the same cycle as the start is still latched.
- R8: If no done arrives within `RST_LIMIT` cycles of the start, `rst_timeout_o` goes high on the cycle after the `RST_LIMIT`-th busy cycle. It stays high until done is seen.
- R9: Command status bits 31:18 and 15:1 read as 0 and ignore writes. A write of 0 to bit 0 has no effect. Reads of unmapped codes return 0.
- R10: After reset, every register reads 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_vld | input | 1 | Register command valid this cycle |
| bus_cmd | input | 8 | Command code, bit 7 = write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for a valid read command, else 0 |
| evt_i | input | EVT_W | Event pulses for status bits EVT_W..1 |
| sched_ovr_i | input | 1 | Scheduling-overrun pulse |
| rst_done_i | input | 1 | Reset sequencer reports completion |
| irq_o | output | 1 | Combined interrupt |
| rst_req_o | output | 1 | Controller software reset in progress |
| rst_timeout_o | output | 1 | Reset exceeded its time bound |

## Verification
Two cases are hard to reach from the ports.

The first is the collision between a hardware set and a software clear on the same bit. The bench reaches it by driving the event pulse and the 0x83 write in the same cycle, between falling edges, so both land on one rising edge.

The second is the timeout. It only appears after hundreds of busy cycles with the done input held low. The bench counts falling edges from the start write and samples one cycle before and one cycle after the bound.

Overrun wrap-around while the flag is pending is reached by four pulses that are never cleared.

// File: rtl/hc_status_pkg.sv
package hc_status_pkg;
    localparam logic [6:0] ADDR_CMDST = 7'h02;
    localparam logic [6:0] ADDR_INTST = 7'h03;
    localparam logic [6:0] ADDR_INTEN = 7'h04;
    localparam int         WR_FLAG    = 7;
    localparam int         MASTER_BIT = 31;
    localparam int         OVR_LSB    = 16;

    typedef enum logic [1:0] {
        RST_IDLE = 2'd0,
        RST_BUSY = 2'd1,
        RST_LATE = 2'd2
    } rst_state_t;
endpackage

// File: rtl/hc_int_regs.sv
module hc_int_regs #(
    parameter int ST_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_i,
    input  logic [ST_W-1:0] clr_i,
    input  logic            flush_i,
    input  logic            en_wr_i,
    input  logic [ST_W-1:0] en_wdata_i,
    input  logic            master_wdata_i,
    output logic [ST_W-1:0] st_o,
    output logic [ST_W-1:0] en_o,
    output logic            master_o,
    output logic            irq_o
);
    logic [ST_W-1:0] st_q;
    logic [ST_W-1:0] en_q;
    logic            master_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (flush_i) begin
            st_q <= set_i;
        end else begin
            st_q <= (st_q & ~clr_i) | set_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            master_q <= 1'b0;
        end else if (flush_i) begin
            en_q     <= '0;
            master_q <= 1'b0;
        end else if (en_wr_i) begin
            en_q     <= en_wdata_i;
            master_q <= master_wdata_i;
        end
    end

    assign st_o     = st_q;
    assign en_o     = en_q;
    assign master_o = master_q;
    assign irq_o    = master_q & (|(st_q & en_q));

    assert_hw_only_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q & ~$past(st_q) & ~$past(set_i)) == '0));

    assert_clear_by_sw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(st_q) & ~st_q) & ~$past(clr_i)) == '0) || $past(flush_i)));

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~st_q & $past(set_i)) == '0));
endmodule

// File: rtl/hc_cmd_status.sv
module hc_cmd_status
    import hc_status_pkg::*;
#(
    parameter int RST_LIMIT = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req_i,
    input  logic       ovr_i,
    input  logic       done_i,
    output logic       flush_o,
    output logic       hcr_o,
    output logic [1:0] ovr_cnt_o,
    output logic       req_o,
    output logic       timeout_o
);
    localparam int CNT_W = $clog2(RST_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_LIMIT - 1);

    rst_state_t       state_q, state_d;
    logic [CNT_W-1:0] cyc_q;
    logic [1:0]       ovr_q;
    logic             start;

    assign start = start_req_i && (state_q == RST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RST_IDLE: if (start_req_i) state_d = RST_BUSY;
            RST_BUSY: begin
                if (done_i)             state_d = RST_IDLE;
                else if (cyc_q == LAST) state_d = RST_LATE;
            end
            RST_LATE: if (done_i) state_d = RST_IDLE;
            default:  state_d = RST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cyc_q <= '0;
        else if (start)                cyc_q <= '0;
        else if (state_q == RST_BUSY)  cyc_q <= cyc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ovr_q <= 2'b00;
        else if (start) ovr_q <= {1'b0, ovr_i};
        else if (ovr_i) ovr_q <= ovr_q + 2'd1;
    end

    always_comb begin
        flush_o   = start;
        ovr_cnt_o = ovr_q;
        hcr_o     = (state_q != RST_IDLE);
        req_o     = (state_q != RST_IDLE);
        timeout_o = (state_q == RST_LATE);
    end

    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_i && !start) |=> (ovr_q == $past(ovr_q) + 2'd1));

    assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RST_IDLE && done_i) |=> (state_q == RST_IDLE));

    assert_flush_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ovr_i) |=> (ovr_q == 2'b00));

    assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RST_BUSY) |-> (cyc_q < CNT_W'(RST_LIMIT)));

    assert_late_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> ($past(cyc_q) == LAST));
endmodule

// File: rtl/hc_status_regs.sv
module hc_status_regs
    import hc_status_pkg::*;
#(
    parameter int EVT_W     = 6,
    parameter int CLK_MHZ   = 50,
    parameter int RESET_US  = 10,
    localparam int ST_W     = EVT_W + 1,
    localparam int RST_LIMIT = CLK_MHZ * RESET_US
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_vld,
    input  logic [7:0]       bus_cmd,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             sched_ovr_i,
    input  logic             rst_done_i,
    output logic             irq_o,
    output logic             rst_req_o,
    output logic             rst_timeout_o
);
    logic            wr, rd;
    logic [6:0]      addr;
    logic [ST_W-1:0] st, en, clr, set;
    logic            master, flush, hcr;
    logic [1:0]      ovr_cnt;

    assign wr   = bus_vld &&  bus_cmd[WR_FLAG];
    assign rd   = bus_vld && !bus_cmd[WR_FLAG];
    assign addr = bus_cmd[6:0];
    assign set  = {evt_i, sched_ovr_i};
    assign clr  = (wr && addr == ADDR_INTST) ? bus_wdata[ST_W-1:0] : '0;

    hc_int_regs #(.ST_W(ST_W)) u_int (
        .clk            (clk),
        .rst_n          (rst_n),
        .set_i          (set),
        .clr_i          (clr),
        .flush_i        (flush),
        .en_wr_i        (wr && addr == ADDR_INTEN),
        .en_wdata_i     (bus_wdata[ST_W-1:0]),
        .master_wdata_i (bus_wdata[MASTER_BIT]),
        .st_o           (st),
        .en_o           (en),
        .master_o       (master),
        .irq_o          (irq_o)
    );

    hc_cmd_status #(.RST_LIMIT(RST_LIMIT)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req_i (wr && addr == ADDR_CMDST && bus_wdata[0]),
        .ovr_i       (sched_ovr_i),
        .done_i      (rst_done_i),
        .flush_o     (flush),
        .hcr_o       (hcr),
        .ovr_cnt_o   (ovr_cnt),
        .req_o       (rst_req_o),
        .timeout_o   (rst_timeout_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (addr)
                ADDR_CMDST: begin
                    bus_rdata[0]                 = hcr;
                    bus_rdata[OVR_LSB+1:OVR_LSB] = ovr_cnt;
                end
                ADDR_INTST: bus_rdata[ST_W-1:0] = st;
                ADDR_INTEN: begin
                    bus_rdata[ST_W-1:0]   = en;
                    bus_rdata[MASTER_BIT] = master;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assert_irq_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> master);

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == ADDR_CMDST) |-> (bus_rdata[31:18] == '0 && bus_rdata[15:1] == '0));
endmodule

// File: tb/hc_status_regs_tb.sv
`timescale 1ns/1ps
module hc_status_regs_tb;
    localparam int EVT_W = 6;
    localparam int LIMIT = 500;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_vld = 1'b0;
    logic [7:0]       bus_cmd = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [EVT_W-1:0] evt_i = '0;
    logic             sched_ovr_i = 1'b0;
    logic             rst_done_i = 1'b0;
    logic             irq_o, rst_req_o, rst_timeout_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hc_status_regs #(.EVT_W(EVT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_cmd(bus_cmd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
        .sched_ovr_i(sched_ovr_i), .rst_done_i(rst_done_i), .irq_o(irq_o),
        .rst_req_o(rst_req_o), .rst_timeout_o(rst_timeout_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        bus_vld = 1'b1; bus_cmd = {1'b1, a}; bus_wdata = d;
        @(negedge clk);
        bus_vld = 1'b0; bus_cmd = '0; bus_wdata = '0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] d);
        bus_vld = 1'b1; bus_cmd = {1'b0, a};
        #1 d = bus_rdata;
        bus_vld = 1'b0; bus_cmd = '0;
    endtask

    task automatic pulse_evt(logic [EVT_W-1:0] e, logic o);
        evt_i = e; sched_ovr_i = o;
        @(negedge clk);
        evt_i = '0; sched_ovr_i = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(7'h02, d); check("R10 cmdst", d, 0);
        rd(7'h03, d); check("R10 intst", d, 0);
        rd(7'h04, d); check("R10 inten", d, 0);
        check("R10 outs", {irq_o, rst_req_o, rst_timeout_o}, 0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        pulse_evt(6'b000101, 1'b0);
        rd(7'h03, d); check("R1 events latch", d, 32'h0A);
        wr(7'h03, 32'h01);
        rd(7'h03, d); check("R1 sw cannot set", d, 32'h0A);
        wr(7'h03, 32'h02);
        rd(7'h03, d); check("R2 clear one", d, 32'h08);
        wr(7'h03, 32'h00);
        rd(7'h03, d); check("R2 zero keeps", d, 32'h08);
        wr(7'h03, 32'h08);
        rd(7'h03, d); check("R2 clear last", d, 32'h00);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        pulse_evt(6'b000011, 1'b0);
        evt_i = 6'b000001;
        bus_vld = 1'b1; bus_cmd = 8'h83; bus_wdata = 32'h06;
        @(negedge clk);
        evt_i = '0; bus_vld = 1'b0; bus_cmd = '0; bus_wdata = '0;
        rd(7'h03, d); check("R3 set wins", d, 32'h02);
        wr(7'h03, 32'h7F);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        pulse_evt(6'b000100, 1'b0);
        wr(7'h04, 32'h08);
        #1 check("R4 no master", irq_o, 0);
        rd(7'h04, d); check("R4 enable readback", d, 32'h08);
        wr(7'h04, 32'h8000_0008);
        #1 check("R4 irq on", irq_o, 1);
        wr(7'h04, 32'h8000_0004);
        #1 check("R4 other enable", irq_o, 0);
        wr(7'h04, 32'h8000_0008);
        wr(7'h03, 32'h08);
        #1 check("R4 cleared status", irq_o, 0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        for (int i = 1; i <= 4; i++) begin
            pulse_evt('0, 1'b1);
            rd(7'h02, d); check("R5 count", d, (i % 4) << 16);
            rd(7'h03, d); check("R5 flag held", d, 32'h01);
        end
        pulse_evt('0, 1'b1);
        wr(7'h82, 32'hFFFF_FFFE);
        rd(7'h02, d); check("R9 reserved ignore", d, 32'h0001_0000);
        #1 check("R9 no reset", rst_req_o, 0);
        rd(7'h15, d); check("R9 unmapped", d, 0);
    endtask

    task automatic t_sw_reset();
        logic [31:0] d;
        pulse_evt(6'b000011, 1'b0);
        wr(7'h04, 32'h8000_0006);
        evt_i = 6'b100000;
        bus_vld = 1'b1; bus_cmd = 8'h82; bus_wdata = 32'h1;
        @(negedge clk);
        evt_i = '0; bus_vld = 1'b0; bus_cmd = '0; bus_wdata = '0;
        rd(7'h02, d); check("R6 R7 hcr set count clear", d, 32'h1);
        #1 check("R6 req", rst_req_o, 1);
        rd(7'h03, d); check("R7 status flushed", d, 32'h40);
        rd(7'h04, d); check("R7 enable flushed", d, 0);
        repeat (10) @(negedge clk);
        rst_done_i = 1'b1;
        @(negedge clk);
        rst_done_i = 1'b0;
        rd(7'h02, d); check("R6 hcr clear", d, 0);
        check("R6 req drop", {rst_req_o, rst_timeout_o}, 0);
        wr(7'h03, 32'h7F);
    endtask

    task automatic t_timeout();
        wr(7'h02, 32'h1);
        repeat (LIMIT - 1) @(negedge clk);
        check("R8 not yet", rst_timeout_o, 0);
        @(negedge clk);
        check("R8 timeout", rst_timeout_o, 1);
        repeat (3) @(negedge clk);
        check("R8 held", {rst_timeout_o, rst_req_o}, 2'b11);
        rst_done_i = 1'b1;
        @(negedge clk);
        rst_done_i = 1'b0;
        check("R8 late done", {rst_timeout_o, rst_req_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_set_clear();
        t_set_wins();
        t_irq();
        t_overrun();
        t_sw_reset();
        t_timeout();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule